// File: doc/BRIEF.md
# Multi-rate video data-valid strobe generator

This block makes a one-bit data-valid strobe in the transmit parallel clock domain. The strobe works as a clock enable that qualifies each parallel video word. The clock itself runs at one fixed rate, nominally 148.5 MHz or 148.35 MHz, and is never gated. A 3-bit standard-select input sets the strobe cadence. Standard definition uses an uneven 11-cycle pattern with two pulses, which gives an average of one word per 5.5 clocks. High definition pulses on alternate cycles. The 3G, 6G and 12G standards hold the strobe high.

One counter path serves each cadence: a modulo-11 counter for SD and a one-bit toggle for HD. The constant-high group needs no counter. A synchronous reset clears both counters. A change of the select code also clears them, so the new cadence always starts from the beginning of its sequence. The strobe is taken straight from a flop.

Top module: `vidstb_gen`

## Requirements
- R1: At a clock edge with `rst` high, the strobe becomes 0 and the cadence counters clear, whatever code `std_sel` carries. The clock edge after a reset edge counts as edge 1.
- R2: With `std_sel` = 000 (SD), the strobe is high after edges n where n mod 11 is 5 or 0, and low after every other edge. Edges are counted from the last reset or restart edge.
- R3: In steady SD operation, any 11 consecutive cycles hold exactly two high strobes, and a high strobe is never followed directly by another.
- R4: With `std_sel` = 001 (HD), the strobe is high after even-numbered edges and low after odd ones. The first pulse therefore follows edge 2.
- R5: With `std_sel` = 010 (3G), 011 (6G) or 100 (12G), the strobe is high after every edge that is not a reset edge.
- R6: The unused codes 101, 110 and 111 behave exactly like the constant-high group.
- R7: At an edge where `std_sel` differs from its value at the previous edge, the counters clear. On that edge the strobe becomes 0 if the new code is SD or HD, and 1 otherwise. Later edges are counted from this edge as in R2 and R4.
- R8: The strobe is a registered output. A change on `std_sel` between clock edges leaves `data_valid` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 3 | Video standard code (000 SD, 001 HD, 010 3G, 011 6G, 100 12G, others treated as constant high) |
| data_valid | output | 1 | Registered data-valid strobe |

## Verification
The bench builds the block with its default parameters: an 11-cycle SD frame with hits at counts 4 and 10. This keeps every cadence short enough to sweep in full. It runs all eight select codes from reset. It then runs every ordered pair of distinct codes as a mid-stream switch, which reaches each restart corner, including a switch into or out of SD at every frame phase the switch timing produces. Sliding 11-cycle windows check the SD pulse density, and mid-cycle select changes check that the output is registered.

// File: rtl/vidstb_pkg.sv
package vidstb_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] STD_SD  = 3'd0;
  localparam logic [SEL_W-1:0] STD_HD  = 3'd1;
  localparam logic [SEL_W-1:0] STD_3G  = 3'd2;
  localparam logic [SEL_W-1:0] STD_6G  = 3'd3;
  localparam logic [SEL_W-1:0] STD_12G = 3'd4;

  typedef enum logic [1:0] {
    CAD_SD   = 2'd0,
    CAD_HD   = 2'd1,
    CAD_HIGH = 2'd2
  } cadence_e;

  function automatic cadence_e cadence_of(input logic [SEL_W-1:0] sel);
    case (sel)
      STD_SD:  return CAD_SD;
      STD_HD:  return CAD_HD;
      default: return CAD_HIGH;
    endcase
  endfunction
endpackage

// File: rtl/vidstb_sel_track.sv
module vidstb_sel_track
  import vidstb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             changed
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    sel_q <= sel;
  end

  assign changed = !rst && (sel != sel_q);

  // R7: after a change edge, the stored code follows the input
  assert_sel_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    changed |=> (sel_q == $past(sel)));
endmodule

// File: rtl/vidstb_sd_ctr.sv
module vidstb_sd_ctr #(
  parameter int PERIOD = 11,
  parameter int HIT_A  = 4,
  parameter int HIT_B  = 10
) (
  input  logic clk,
  input  logic clr,
  output logic hit
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit = (cnt_q == CNT_W'(HIT_A)) || (cnt_q == CNT_W'(HIT_B));

  // R2: the frame counter never leaves its range
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= LAST);

  // R1: a clear always returns the count to zero
  assert_cnt_clear_R1: assert property (@(posedge clk)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/vidstb_hd_tog.sv
module vidstb_hd_tog (
  input  logic clk,
  input  logic clr,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (clr) begin
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
    end
  end

  // R4: the toggle alternates between clears
  assert_tog_alt_R4: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (phase != $past(phase)));
endmodule

// File: rtl/vidstb_gen.sv
module vidstb_gen
  import vidstb_pkg::*;
#(
  parameter int SD_PERIOD = 11,
  parameter int SD_HIT_A  = 4,
  parameter int SD_HIT_B  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] std_sel,
  output logic             data_valid
);
  logic     sel_changed;
  logic     restart;
  logic     sd_hit;
  logic     hd_phase;
  logic     strobe_q;
  logic     steady_q;
  cadence_e mode;

  assign mode    = cadence_of(std_sel);
  assign restart = rst || sel_changed;

  vidstb_sel_track u_track (
    .clk     (clk),
    .rst     (rst),
    .sel     (std_sel),
    .changed (sel_changed)
  );

  vidstb_sd_ctr #(
    .PERIOD (SD_PERIOD),
    .HIT_A  (SD_HIT_A),
    .HIT_B  (SD_HIT_B)
  ) u_sd (
    .clk (clk),
    .clr (restart),
    .hit (sd_hit)
  );

  vidstb_hd_tog u_hd (
    .clk   (clk),
    .clr   (restart),
    .phase (hd_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      steady_q <= 1'b0;
    end else begin
      steady_q <= !sel_changed;
      if (sel_changed) begin
        strobe_q <= (mode == CAD_HIGH);
      end else begin
        case (mode)
          CAD_SD:  strobe_q <= sd_hit;
          CAD_HD:  strobe_q <= hd_phase;
          default: strobe_q <= 1'b1;
        endcase
      end
    end
  end

  assign data_valid = strobe_q;

  // R1: reset edge forces the strobe low
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !strobe_q);

  // R3: in steady SD no two strobes are adjacent
  assert_sd_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (steady_q && !sel_changed && mode == CAD_SD && strobe_q) |=> !strobe_q);

  // R4: in steady HD the strobe alternates
  assert_hd_alt_R4: assert property (@(posedge clk) disable iff (rst)
    (steady_q && !sel_changed && mode == CAD_HD) |=> (strobe_q != $past(strobe_q)));

  // R5: constant-high group keeps the strobe up
  assert_high_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == CAD_HIGH) |=> strobe_q);

  // R7: switching into a counted cadence starts low
  assert_restart_low_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_changed && mode != CAD_HIGH) |=> !strobe_q);
endmodule

// File: tb/vidstb_gen_tb_top.sv
module vidstb_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] std_sel = 3'd0;
  logic       data_valid;

  int n_checks = 0;
  int n_fail   = 0;

  int         ph;
  logic [2:0] prev_sel;
  logic       exp_v;
  logic [10:0] hist;

  always #10 clk = ~clk;

  vidstb_gen dut_i (
    .clk        (clk),
    .rst        (rst),
    .std_sel    (std_sel),
    .data_valid (data_valid)
  );

  function automatic logic is_high(input logic [2:0] s);
    return (s != 3'd0) && (s != 3'd1);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: data_valid=%0b expected %0b (sel=%0d ph=%0d)",
               tag, act, exp, std_sel, ph);
    end
  endtask

  task automatic cyc(input logic r, input logic [2:0] s);
    string tag;
    rst = r;
    std_sel = s;
    @(posedge clk);
    if (r) begin
      ph = 0; exp_v = 1'b0; prev_sel = s; tag = "R1";
    end else if (s != prev_sel) begin
      ph = 0; exp_v = is_high(s); prev_sel = s; tag = "R7";
    end else begin
      ph++;
      if (s == 3'd0) begin
        exp_v = ((ph % 11) == 5) || ((ph % 11) == 0); tag = "R2";
      end else if (s == 3'd1) begin
        exp_v = ((ph % 2) == 0); tag = "R4";
      end else begin
        exp_v = 1'b1; tag = (s > 3'd4) ? "R6" : "R5";
      end
    end
    #5;
    check(tag, data_valid, exp_v);
    hist = {hist[9:0], data_valid};
    if (!r && s == 3'd0 && ph >= 11) begin
      n_checks++;
      if ($countones(hist) != 2 || (hist[0] && hist[1])) begin
        n_fail++;
        $display("FAIL R3: window ones=%0d expected 2 (last two %0b%0b)",
                 $countones(hist), hist[1], hist[0]);
      end
    end
  endtask

  initial begin
    #200000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    hist = '0;
    ph = 0;
    prev_sel = 3'd0;
    // every code straight from reset
    for (int c = 0; c < 8; c++) begin
      cyc(1'b1, 3'(c));
      cyc(1'b1, 3'(c));
      for (int k = 0; k < 34; k++) cyc(1'b0, 3'(c));
    end
    // every ordered pair of codes as a mid-stream switch
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (a != b) begin
          cyc(1'b1, 3'(a));
          for (int k = 0; k < 7 + a + b; k++) cyc(1'b0, 3'(a));
          for (int k = 0; k < 24; k++) cyc(1'b0, 3'(b));
        end
      end
    end
    // reset in the middle of a counted cadence
    for (int k = 0; k < 8; k++) cyc(1'b0, 3'd1);
    cyc(1'b1, 3'd0);
    for (int k = 0; k < 30; k++) cyc(1'b0, 3'd0);
    // R8: changing select between edges does not move the output
    for (int c = 0; c < 8; c++) begin
      logic held;
      cyc(1'b0, std_sel);
      held = data_valid;
      std_sel = 3'(c) ^ 3'd5;
      #1;
      check("R8", data_valid, held);
      std_sel = prev_sel;
      #1;
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule